// File: doc/BRIEF.md
# Reference-Gated Frequency Meter

This block measures how fast a target clock runs by counting its edges over a gate window timed by a slower reference clock. Both clocks reach the block as single-cycle tick strobes in the system clock domain. Two 3-bit selects pick one of seven target tick lines and one of seven reference tick lines. A window field sets the gate length: a value of N gives N+1 reference periods, so 0 is one full reference period. A 16-bit result register holds the count. For example, a 26 MHz target against a 32.768 kHz reference with window 0 reads about 794.

Software sets the high-speed enable, then raises the meter enable. It polls busy until busy drops, reads the result, and then clears the meter enable. A synchronous measurement reset clears the result and busy.

The controller is a four-state machine:
- `ST_IDLE`: waits for both enables.
- `ST_ARM`: busy is set and the machine waits for the first reference tick.
- `ST_GATE`: counting runs and whole reference periods are tallied.
- `ST_HOLD`: the result is latched and busy is low until the enable is removed.

Transitions:
- IDLE→ARM on start: both enables high.
- ARM→GATE on the opening tick.
- GATE→HOLD on the closing tick.
- ARM→IDLE and GATE→IDLE on abort: the meter enable is removed.
- HOLD→IDLE on release: the meter enable is removed.
- Any state→IDLE on the measurement reset.

Top module: `freq_meter`

## Requirements
- R1: After `rst_n` low, or one cycle after `meas_srst` is high, `busy` is 0 and `count_data` is 0, whatever state the meter was in.
- R2: A measurement starts (IDLE→ARM) at the first clock edge at which both `meter_en` and `hs_clk_en` are 1. `busy` reads 1 from the next cycle on.
- R3: If `meter_en` is 1 while `hs_clk_en` is 0, `busy` stays 0 and `count_data` keeps its value.
- R4: The gate opens at the first selected reference tick after the start (ARM→GATE). Target ticks before that tick, and in the same cycle as it, are not counted.
- R5: The gate closes on the (W+1)-th selected reference tick after the opening one, where W is the window value. Target ticks are counted in every gate cycle, including the cycle of the closing tick.
- R6: A window value of 0 gives a gate of exactly one reference period.
- R7: The result is loaded into `count_data` at the clock edge of the closing tick, and `busy` falls at that same edge. `busy` then stays 0 (HOLD) while `meter_en` remains 1.
- R8: The count saturates at 0xFFFF instead of wrapping.
- R9: Clearing `meter_en` while `busy` is 1 returns the meter to IDLE. `busy` is 0 the next cycle and `count_data` is left unchanged.
- R10: A select value s from 0 to 6 picks tick line bit s of `tgt_ticks` (or `ref_ticks`). A select value of 7 picks no line, so nothing is counted. Unselected lines have no effect.
- R11: The window value is captured at the start. Changing `win_size` during a measurement has no effect on that measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_srst | input | 1 | Synchronous measurement reset; clears result and busy |
| meter_en | input | 1 | Meter enable; start, abort and release |
| hs_clk_en | input | 1 | High-speed clock enable; required to start |
| tgt_sel | input | 3 | Target tick line select |
| ref_sel | input | 3 | Reference tick line select |
| win_size | input | 16 | Gate length in reference periods minus one |
| tgt_ticks | input | 7 | Target clock tick strobes |
| ref_ticks | input | 7 | Reference clock tick strobes |
| busy | output | 1 | High from start until the result is latched |
| count_data | output | 16 | Latched saturating count |

## Verification
The embedded properties check the following on every cycle:
- `busy` can only rise after both enables were present.
- `busy` cannot start while the high-speed enable is low.
- An abort drops `busy` and freezes the result.
- The measurement reset clears the result and `busy`.
- The result changes only at the fall of `busy` or at a reset.
- The saturated counter holds at its ceiling.

Only the bench scenarios can show that the count is right. They drive patterned target ticks against chosen reference periods, with noise on every unselected line, and compare each latched result with the count the requirements predict. These scenarios cover the exclusion of ticks before and during the opening tick, the window+1 period length, the window change during a measurement, the empty select value, and the long run that reaches saturation.

// File: rtl/fmeter_pkg.sv
package fmeter_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_GATE,
        ST_HOLD
    } gate_state_t;

    localparam int unsigned SRC_COUNT = 7;
    localparam int unsigned SEL_BITS  = 3;
endpackage

// File: rtl/fm_tick_pick.sv
module fm_tick_pick #(
    parameter int unsigned N_LINES = 7,
    parameter int unsigned SEL_W   = 3
) (
    input  logic [N_LINES-1:0] ticks,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick
);
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            if (sel == SEL_W'(i)) begin
                tick = ticks[i];
            end
        end
    end
endmodule

// File: rtl/fm_sat_count.sv
module fm_sat_count #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] CEIL = {W{1'b1}};

    always_comb begin
        if (inc && value != CEIL) begin
            nxt = value + W'(1);
        end else begin
            nxt = value;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else begin
            value <= nxt;
        end
    end

    // R8: once at the ceiling the count never wraps
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (value == CEIL && !clr) |=> (value == CEIL));
endmodule

// File: rtl/fm_gate_fsm.sv
module fm_gate_fsm
    import fmeter_pkg::*;
#(
    parameter int unsigned WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             meter_en,
    input  logic             hs_en,
    input  logic             ref_tick,
    input  logic [WIN_W-1:0] win_size,
    output logic             busy,
    output logic             cnt_clr,
    output logic             gate_on,
    output logic             latch
);
    gate_state_t      state, state_nxt;
    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] periods;
    logic             last_period;

    assign last_period = (periods == win_q);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (meter_en && hs_en) state_nxt = ST_ARM;
            ST_ARM:  if (!meter_en) state_nxt = ST_IDLE;
                     else if (ref_tick) state_nxt = ST_GATE;
            ST_GATE: if (!meter_en) state_nxt = ST_IDLE;
                     else if (ref_tick && last_period) state_nxt = ST_HOLD;
            ST_HOLD: if (!meter_en) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            win_q   <= '0;
            periods <= '0;
        end else if (srst) begin
            state   <= ST_IDLE;
            periods <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE && state_nxt == ST_ARM) begin
                win_q <= win_size;
            end
            if (state == ST_ARM && ref_tick) begin
                periods <= '0;
            end else if (state == ST_GATE && ref_tick) begin
                periods <= periods + WIN_W'(1);
            end
        end
    end

    always_comb begin
        busy    = (state == ST_ARM) || (state == ST_GATE);
        cnt_clr = (state == ST_ARM) && ref_tick;
        gate_on = (state == ST_GATE);
        latch   = (state == ST_GATE) && meter_en && ref_tick && last_period;
    end

    // R2: busy only rises after both enables were present
    a_r2_start_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(meter_en && hs_en));
    // R3: no start without the high-speed enable
    a_r3_no_hs_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !hs_en) |=> !busy);
    // R9: removing the enable ends the run
    a_r9_abort_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !meter_en) |=> !busy);
endmodule

// File: rtl/freq_meter.sv
module freq_meter
    import fmeter_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned WIN_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                meas_srst,
    input  logic                meter_en,
    input  logic                hs_clk_en,
    input  logic [SEL_BITS-1:0] tgt_sel,
    input  logic [SEL_BITS-1:0] ref_sel,
    input  logic [WIN_W-1:0]    win_size,
    input  logic [SRC_COUNT-1:0] tgt_ticks,
    input  logic [SRC_COUNT-1:0] ref_ticks,
    output logic                busy,
    output logic [CNT_W-1:0]    count_data
);
    logic             tgt_tick, ref_tick;
    logic             cnt_clr, gate_on, latch;
    logic [CNT_W-1:0] cnt_val, cnt_nxt;

    fm_tick_pick #(.N_LINES(SRC_COUNT), .SEL_W(SEL_BITS)) u_tgt_pick (
        .ticks (tgt_ticks),
        .sel   (tgt_sel),
        .tick  (tgt_tick)
    );

    fm_tick_pick #(.N_LINES(SRC_COUNT), .SEL_W(SEL_BITS)) u_ref_pick (
        .ticks (ref_ticks),
        .sel   (ref_sel),
        .tick  (ref_tick)
    );

    fm_gate_fsm #(.WIN_W(WIN_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (meas_srst),
        .meter_en (meter_en),
        .hs_en    (hs_clk_en),
        .ref_tick (ref_tick),
        .win_size (win_size),
        .busy     (busy),
        .cnt_clr  (cnt_clr),
        .gate_on  (gate_on),
        .latch    (latch)
    );

    fm_sat_count #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (gate_on && tgt_tick),
        .value (cnt_val),
        .nxt   (cnt_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_data <= '0;
        end else if (meas_srst) begin
            count_data <= '0;
        end else if (latch) begin
            count_data <= cnt_nxt;
        end
    end

    // R1: measurement reset clears result and busy
    a_r1_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        meas_srst |=> (count_data == '0 && !busy));
    // R9: an abort leaves the result untouched
    a_r9_abort_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !meter_en && !meas_srst) |=> $stable(count_data));
    // R7: result moves only as busy falls, or on reset
    a_r7_data_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count_data) |-> ($fell(busy) || $past(meas_srst)));
endmodule

// File: tb/freq_meter_tb.sv
module freq_meter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        meas_srst = 1'b0;
    logic        meter_en = 1'b0;
    logic        hs_clk_en = 1'b0;
    logic [2:0]  tgt_sel = '0;
    logic [2:0]  ref_sel = '0;
    logic [15:0] win_size = '0;
    logic [6:0]  tgt_ticks = '0;
    logic [6:0]  ref_ticks = '0;
    logic        busy;
    logic [15:0] count_data;

    int nchk = 0;
    int nerr = 0;
    int exp_q[$];
    int last_data = 0;
    int fall_kind = 0;
    bit prev_busy = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    freq_meter u_dut (
        .clk(clk), .rst_n(rst_n), .meas_srst(meas_srst), .meter_en(meter_en),
        .hs_clk_en(hs_clk_en), .tgt_sel(tgt_sel), .ref_sel(ref_sel),
        .win_size(win_size), .tgt_ticks(tgt_ticks), .ref_ticks(ref_ticks),
        .busy(busy), .count_data(count_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] line_mask(input int sel);
        return (sel < 7) ? 7'(1 << sel) : 7'h00;
    endfunction

    // noise on every unselected line, pattern on the selected one
    task automatic drive(input int tsel, input int rsel, input bit t, input bit r);
        tgt_ticks = (7'h7f & ~line_mask(tsel)) | (t ? line_mask(tsel) : 7'h00);
        ref_ticks = (7'h7f & ~line_mask(rsel)) | (r ? line_mask(rsel) : 7'h00);
    endtask

    // monitor: compares each latched result with the queued expectation
    always @(negedge clk) begin
        if (prev_busy && !busy) begin
            if (fall_kind == 1) begin
                chk(count_data == 16'(last_data), "R9 data kept on abort", count_data, last_data);
                fall_kind = 0;
            end else if (fall_kind == 2) begin
                fall_kind = 0;
            end else if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected result", count_data, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(count_data == 16'(e), "R5 latched count", count_data, e);
                last_data = e;
            end
        end
        prev_busy = busy;
    end

    task automatic start(input int tsel, input int rsel, input int win);
        @(negedge clk);
        tgt_sel = 3'(tsel); ref_sel = 3'(rsel); win_size = 16'(win);
        hs_clk_en = 1'b1; meter_en = 1'b1;
        drive(tsel, rsel, 1'b1, 1'b0);
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
    endtask

    task automatic measure(input int tsel, input int rsel, input int win,
                           input int gap, input int pre, input bit chg_win);
        int e;
        e = (tsel >= 7) ? 0 : (win + 1) * (gap + 1);
        if (e > 65535) e = 65535;
        exp_q.push_back(e);
        start(tsel, rsel, win);
        for (int i = 0; i < pre; i++) begin
            drive(tsel, rsel, 1'b1, 1'b0);
            @(negedge clk);
        end
        drive(tsel, rsel, 1'b1, 1'b1);   // opening tick, R4: target here not counted
        @(negedge clk);
        if (chg_win) win_size = 16'(win + 5);   // R11: must be ignored
        for (int p = 0; p <= win; p++) begin
            for (int g = 0; g < gap; g++) begin
                drive(tsel, rsel, 1'b1, 1'b0);
                @(negedge clk);
            end
            drive(tsel, rsel, 1'b1, 1'b1);
            @(negedge clk);
        end
        chk(busy == 1'b0, "R7 busy low at close", busy, 0);
        drive(tsel, rsel, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R7 hold keeps busy low", busy, 0);
        chk(count_data == 16'(e), "R7 result held", count_data, e);
        meter_en = 1'b0;
        drive(7, 7, 1'b0, 1'b0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(count_data == 16'd0, "R1 data after reset", count_data, 0);

        measure(4, 2, 0, 23, 3, 1'b0);     // R6, R4: 24
        measure(0, 3, 3, 9, 2, 1'b0);      // R5: 40
        measure(2, 2, 2, 4, 0, 1'b1);      // R11: 15
        measure(6, 0, 1, 5, 1, 1'b0);      // R10 line 6: 12
        measure(7, 0, 1, 5, 1, 1'b0);      // R10 empty select: 0

        // R9 abort mid-gate
        last_data = 99;
        measure(1, 4, 0, 98, 0, 1'b0);     // sets result 99
        start(1, 4, 2);
        drive(1, 4, 1'b1, 1'b1);
        @(negedge clk);
        repeat (4) begin drive(1, 4, 1'b1, 1'b0); @(negedge clk); end
        fall_kind = 1;
        meter_en = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R9 busy after abort", busy, 0);
        chk(count_data == 16'd99, "R9 data after abort", count_data, 99);

        // R3 no high-speed enable
        @(negedge clk);
        hs_clk_en = 1'b0; meter_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            drive(1, 4, 1'b1, i[0]);
            @(negedge clk);
            chk(busy == 1'b0, "R3 busy stays low", busy, 0);
        end
        chk(count_data == 16'd99, "R3 data unchanged", count_data, 99);
        meter_en = 1'b0;
        @(negedge clk);

        // R1 measurement reset mid-run
        start(3, 5, 1);
        drive(3, 5, 1'b1, 1'b1);
        @(negedge clk);
        fall_kind = 2;
        meas_srst = 1'b1;
        @(negedge clk);
        meas_srst = 1'b0;
        chk(busy == 1'b0, "R1 busy after srst", busy, 0);
        chk(count_data == 16'd0, "R1 data after srst", count_data, 0);
        meter_en = 1'b0;
        last_data = 0;
        @(negedge clk);

        // R8 saturation: 2 * 40001 ticks
        measure(5, 6, 1, 40000, 1, 1'b0);

        chk(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule